// File: doc/BRIEF.md
# Prefetching DMA read FIFO

This block pulls a contiguous range of memory into a byte FIFO ahead of the consumer. A fill is started with a base address and a byte length. The block then cuts the range into read requests no longer than a configured maximum. Each request is tagged with one slot from a small pool and sent to an external read issuer. Completions come back on the tag and may arrive in any order. The block still commits their data to the FIFO strictly in the order the requests were issued.

Before a request goes out, FIFO space is reserved for it. The bytes already buffered, the bytes still in flight and the bytes of the new request must fit in the FIFO together, so the buffer can never overflow. A fill can be stopped early. Stopping ends request generation and marks every request still in flight as canceled, so their data is dropped when they retire.

The consumer reads between one and four bytes per cycle. A read succeeds only when enough bytes are buffered; a refused read removes nothing. Two one-cycle event outputs are provided:
- an end-of-block event, raised when the fill address catches up with the end address;
- an inactive event, raised when the last in-flight request retires.

Top module: `dpf_prefetch_fifo`

## Requirements
- R1: Out of reset no request is issued, the FIFO is empty (a read of 1 byte is refused) and neither event output is high.
- R2: A fill start is accepted only while the fill address equals the end address; a start arriving mid-fill is ignored and request addresses continue from the running fill.
- R3: Each request's address is the current fill address and its length is the smaller of MAX_REQ and the bytes left to the end address; successive requests are contiguous.
- R4: A request is issued only when a slot is free and buffered bytes plus in-flight bytes plus the new length do not exceed DEPTH; issuing repeats one request per cycle until slots, space or the block run out.
- R5: Slot tags are handed out in rotating order 0, 1, ..., SLOTS-1, 0, ...; a tag is never reused while its request is still in flight.
- R6: Data is committed in issue order, whatever order completions arrive in. Completion byte k sits in bits [8k+7:8k] of the completion data.
- R7: A stop issues no further request from the next cycle on, and the data of every request in flight at the stop is discarded when it completes.
- R8: A read of N bytes (1 to 4) succeeds only when at least N bytes are buffered. Otherwise it is refused and removes nothing. The first byte read is in bits [7:0] of the read data.
- R9: The end-of-block output is high for exactly one cycle, the cycle after the fill address reaches the end address from short of it, whether by the last request or by a stop.
- R10: The inactive output is high for exactly one cycle after the number of in-flight requests drops to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a fill (pulse) |
| start_addr_i | input | ADDR_W | Fill base address |
| start_len_i | input | ADDR_W | Fill length in bytes |
| stop_i | input | 1 | Stop the current fill (pulse) |
| req_valid_o | output | 1 | Read request issued this cycle |
| req_addr_o | output | ADDR_W | Request address |
| req_len_o | output | clog2(MAX_REQ+1) | Request length in bytes |
| req_tag_o | output | clog2(SLOTS) | Request slot tag |
| cpl_valid_i | input | 1 | Completion arrives |
| cpl_tag_i | input | clog2(SLOTS) | Completion slot tag |
| cpl_data_i | input | 8*MAX_REQ | Completion data, byte k at [8k+7:8k] |
| rd_en_i | input | 1 | Read request from consumer |
| rd_cnt_i | input | 3 | Bytes to read, 1 to 4 |
| rd_data_o | output | 32 | Buffered bytes, first at [7:0] |
| rd_ok_o | output | 1 | Read accepted this cycle |
| eob_o | output | 1 | End-of-block event |
| idle_o | output | 1 | Inactive event |

## Verification
The bench builds the block with SLOTS=4, MAX_REQ=4 and DEPTH=24. With these values four full requests use up every slot while reserving only 16 bytes. The space limit then binds after two further requests, so the slot limit and the space limit each stop issuing in turn within one fill. A read size of up to four bytes matches one request, so refused reads and partial-request reads both occur in random draining.

// File: rtl/dpf_pkg.sv
// Shared constants of the prefetching read FIFO.
// Assumes the consumer side never reads more than RD_MAX bytes per cycle.
package dpf_pkg;
    localparam int RD_MAX   = 4;
    localparam int RD_CNT_W = 3;
endpackage

// File: rtl/dpf_byte_fifo.sv
// Byte FIFO with a multi-byte write and a multi-byte pop per cycle.
// Assumes the caller never writes beyond free space and never pops more than held.
module dpf_byte_fifo #(
    parameter int DEPTH  = 64,
    parameter int WR_MAX = 8,
    parameter int RD_MAX = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int WL_W  = $clog2(WR_MAX + 1),
    localparam int RC_W  = $clog2(RD_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WL_W-1:0]       wr_len,
    input  logic [8*WR_MAX-1:0]   wr_data,
    input  logic                  pop,
    input  logic [RC_W-1:0]       pop_n,
    output logic [LVL_W-1:0]      level,
    output logic [8*RD_MAX-1:0]   peek
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // Store the written bytes at consecutive positions after the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < WR_MAX; i++) begin
                if (i < int'(wr_len)) mem[wrap_add(wptr, i)] <= wr_data[8*i +: 8];
            end
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_en) wptr <= wrap_add(wptr, int'(wr_len));
            if (pop)   rptr <= wrap_add(rptr, int'(pop_n));
            level <= level + (wr_en ? LVL_W'(wr_len) : '0) - (pop ? LVL_W'(pop_n) : '0);
        end
    end

    // Present the oldest bytes, one lane per output byte.
    for (genvar j = 0; j < RD_MAX; j++) begin : g_lane
        assign peek[8*j +: 8] = mem[wrap_add(rptr, j)];
    end
endmodule

// File: rtl/dpf_slot_ring.sv
// Pool of request slots used in rotating order; retires the oldest slot once done.
// Assumes completions only name slots that are in flight.
module dpf_slot_ring #(
    parameter int SLOTS   = 4,
    parameter int MAX_REQ = 8,
    parameter int DEPTH   = 64,
    localparam int TAG_W  = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int LEN_W  = $clog2(MAX_REQ + 1),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic [LEN_W-1:0]       issue_len,
    input  logic                   stop,
    input  logic                   cpl_valid,
    input  logic [TAG_W-1:0]       cpl_tag,
    input  logic [8*MAX_REQ-1:0]   cpl_data,
    output logic                   slot_free,
    output logic [TAG_W-1:0]       next_tag,
    output logic [LVL_W-1:0]       pend,
    output logic                   retire,
    output logic                   retire_keep,
    output logic [LEN_W-1:0]       retire_len,
    output logic [8*MAX_REQ-1:0]   retire_data,
    output logic                   idle_o
);
    logic [LEN_W-1:0]     len_q  [SLOTS];
    logic [8*MAX_REQ-1:0] data_q [SLOTS];
    logic [SLOTS-1:0]     done_q, cancel_q;
    logic [TAG_W-1:0]     head, tail;
    logic [CNT_W-1:0]     cnt;
    logic                 busy_q;

    function automatic logic [TAG_W-1:0] inc(input logic [TAG_W-1:0] t);
        return (int'(t) == SLOTS - 1) ? '0 : t + 1'b1;
    endfunction

    assign slot_free   = int'(cnt) < SLOTS;
    assign next_tag    = tail;
    assign retire      = (cnt != '0) && done_q[head];
    assign retire_keep = !cancel_q[head];
    assign retire_len  = len_q[head];
    assign retire_data = data_q[head];
    assign idle_o      = (cnt == '0) && busy_q;

    // Per-slot length and completion data.
    always_ff @(posedge clk) begin
        if (issue)     len_q[tail]     <= issue_len;
        if (cpl_valid) data_q[cpl_tag] <= cpl_data;
    end

    // Slot flags, ring pointers, occupancy and in-flight byte total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= '0;
            cancel_q <= '0;
            head     <= '0;
            tail     <= '0;
            cnt      <= '0;
            pend     <= '0;
            busy_q   <= 1'b0;
        end else begin
            if (stop) cancel_q <= '1;
            if (issue) begin
                done_q[tail]   <= 1'b0;
                cancel_q[tail] <= 1'b0;
                tail           <= inc(tail);
            end
            if (cpl_valid) done_q[cpl_tag] <= 1'b1;
            if (retire) head <= inc(head);
            cnt    <= cnt + CNT_W'(issue) - CNT_W'(retire);
            pend   <= pend + (issue ? LVL_W'(issue_len) : '0) - (retire ? LVL_W'(len_q[head]) : '0);
            busy_q <= cnt != '0;
        end
    end
endmodule

// File: rtl/dpf_issue_ctrl.sv
// Holds the fill window and decides, each cycle, whether one more request fits.
// Assumes the read issuer accepts every request in the cycle it is offered.
module dpf_issue_ctrl #(
    parameter int ADDR_W  = 32,
    parameter int MAX_REQ = 8,
    parameter int DEPTH   = 64,
    localparam int LEN_W  = $clog2(MAX_REQ + 1),
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int SUM_W  = LVL_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [ADDR_W-1:0]  start_len,
    input  logic               stop,
    input  logic               slot_free,
    input  logic [LVL_W-1:0]   level,
    input  logic [LVL_W-1:0]   pend,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len,
    output logic               eob_o
);
    logic [ADDR_W-1:0] next_q, end_q, remain;
    logic              at_end, at_end_q, fits;

    assign at_end   = next_q == end_q;
    assign remain   = end_q - next_q;
    assign req_len  = (remain < ADDR_W'(MAX_REQ)) ? LEN_W'(remain) : LEN_W'(MAX_REQ);
    assign fits     = (SUM_W'(level) + SUM_W'(pend) + SUM_W'(req_len)) <= SUM_W'(DEPTH);
    assign req_valid = !at_end && slot_free && fits && !stop;
    assign req_addr = next_q;
    assign eob_o    = at_end && !at_end_q;

    // Fill window: stop closes it, start opens it only when closed, issue advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q   <= '0;
            end_q    <= '0;
            at_end_q <= 1'b1;
        end else begin
            if (stop)
                next_q <= end_q;
            else if (start && at_end) begin
                next_q <= start_addr;
                end_q  <= start_addr + start_len;
            end else if (req_valid)
                next_q <= next_q + ADDR_W'(req_len);
            at_end_q <= at_end;
        end
    end
endmodule

// File: rtl/dpf_prefetch_fifo.sv
// Prefetching read FIFO: issues bounded reads ahead of a byte consumer and
// commits returned data in issue order. Assumes 2 <= SLOTS and DEPTH >= MAX_REQ, 4.
module dpf_prefetch_fifo
    import dpf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLOTS   = 4,
    parameter int MAX_REQ = 8,
    parameter int DEPTH   = 64,
    localparam int TAG_W  = $clog2(SLOTS),
    localparam int LEN_W  = $clog2(MAX_REQ + 1),
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int RC_W   = $clog2(RD_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     start_addr_i,
    input  logic [ADDR_W-1:0]     start_len_i,
    input  logic                  stop_i,
    output logic                  req_valid_o,
    output logic [ADDR_W-1:0]     req_addr_o,
    output logic [LEN_W-1:0]      req_len_o,
    output logic [TAG_W-1:0]      req_tag_o,
    input  logic                  cpl_valid_i,
    input  logic [TAG_W-1:0]      cpl_tag_i,
    input  logic [8*MAX_REQ-1:0]  cpl_data_i,
    input  logic                  rd_en_i,
    input  logic [RD_CNT_W-1:0]   rd_cnt_i,
    output logic [8*RD_MAX-1:0]   rd_data_o,
    output logic                  rd_ok_o,
    output logic                  eob_o,
    output logic                  idle_o
);
    logic                  slot_free, retire, retire_keep;
    logic [LVL_W-1:0]      level, pend;
    logic [LEN_W-1:0]      retire_len;
    logic [8*MAX_REQ-1:0]  retire_data;

    // A read is granted only for a legal count that the FIFO can cover.
    assign rd_ok_o = rd_en_i && (rd_cnt_i != '0) && (int'(rd_cnt_i) <= RD_MAX)
                     && (int'(level) >= int'(rd_cnt_i));

    dpf_issue_ctrl #(.ADDR_W(ADDR_W), .MAX_REQ(MAX_REQ), .DEPTH(DEPTH)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .start(start_i), .start_addr(start_addr_i), .start_len(start_len_i),
        .stop(stop_i), .slot_free(slot_free), .level(level), .pend(pend),
        .req_valid(req_valid_o), .req_addr(req_addr_o), .req_len(req_len_o),
        .eob_o(eob_o)
    );

    dpf_slot_ring #(.SLOTS(SLOTS), .MAX_REQ(MAX_REQ), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .issue(req_valid_o), .issue_len(req_len_o), .stop(stop_i),
        .cpl_valid(cpl_valid_i), .cpl_tag(cpl_tag_i), .cpl_data(cpl_data_i),
        .slot_free(slot_free), .next_tag(req_tag_o), .pend(pend),
        .retire(retire), .retire_keep(retire_keep), .retire_len(retire_len),
        .retire_data(retire_data), .idle_o(idle_o)
    );

    dpf_byte_fifo #(.DEPTH(DEPTH), .WR_MAX(MAX_REQ), .RD_MAX(RD_MAX)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(retire && retire_keep), .wr_len(retire_len), .wr_data(retire_data),
        .pop(rd_ok_o), .pop_n(RC_W'(rd_cnt_i)),
        .level(level), .peek(rd_data_o)
    );
endmodule

// File: rtl/dpf_checker.sv
// Property checker for the prefetching read FIFO, bound into the top module.
// Assumes it observes the top's internal occupancy and in-flight byte count.
module dpf_checker #(
    parameter int MAX_REQ = 8,
    parameter int DEPTH   = 64,
    parameter int LVL_W   = 7,
    parameter int LEN_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_i,
    input logic             req_valid_o,
    input logic [LEN_W-1:0] req_len_o,
    input logic             slot_free,
    input logic             rd_en_i,
    input logic             rd_ok_o,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] pend,
    input logic             eob_o,
    input logic             idle_o
);
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) + int'(pend)) <= DEPTH);
    p_issue_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> slot_free);
    p_req_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_len_o != '0) && (int'(req_len_o) <= MAX_REQ));
    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !req_valid_o);
    p_refused_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_ok_o) |=> level >= $past(level));
    p_eob_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eob_o |=> !eob_o);
    p_idle_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |=> !idle_o);
endmodule

bind dpf_prefetch_fifo dpf_checker #(
    .MAX_REQ(MAX_REQ), .DEPTH(DEPTH), .LVL_W(LVL_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .req_valid_o(req_valid_o),
    .req_len_o(req_len_o), .slot_free(slot_free), .rd_en_i(rd_en_i),
    .rd_ok_o(rd_ok_o), .level(level), .pend(pend), .eob_o(eob_o), .idle_o(idle_o)
);

// File: tb/tb_dpf_prefetch_fifo.sv
module tb_dpf_prefetch_fifo;
    localparam int ADDR_W = 32, SLOTS = 4, MAX_REQ = 4, DEPTH = 24;
    localparam int TAG_W = $clog2(SLOTS), LEN_W = $clog2(MAX_REQ + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, cpl_valid_i = 0, rd_en_i = 0;
    logic [ADDR_W-1:0] start_addr_i = '0, start_len_i = '0;
    logic [TAG_W-1:0] cpl_tag_i = '0;
    logic [8*MAX_REQ-1:0] cpl_data_i = '0;
    logic [2:0] rd_cnt_i = '0;
    logic req_valid_o, rd_ok_o, eob_o, idle_o;
    logic [ADDR_W-1:0] req_addr_o;
    logic [LEN_W-1:0] req_len_o;
    logic [TAG_W-1:0] req_tag_o;
    logic [31:0] rd_data_o;

    dpf_prefetch_fifo #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .MAX_REQ(MAX_REQ), .DEPTH(DEPTH)) dut (.*);

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int issued_n = 0, issued_bytes = 0, read_bytes = 0, eob_n = 0, idle_n = 0;
    int last_req_cyc = 0, eob_cyc = 0;
    bit ovf_chk = 1;
    logic [ADDR_W-1:0] exp_next = '0, exp_end = '0, rd_addr = '0;
    logic [TAG_W-1:0] exp_tag = '0;
    bit out_v [SLOTS];
    logic [ADDR_W-1:0] out_a [SLOTS];

    function automatic logic [7:0] byte_of(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int min_len(input logic [ADDR_W-1:0] rem);
        return (rem < ADDR_W'(MAX_REQ)) ? int'(rem) : MAX_REQ;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Request monitor, event counters and watchdog, sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            check(0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            if (eob_o) begin eob_n++; eob_cyc = cyc; end
            if (idle_o) idle_n++;
            if (req_valid_o) begin
                check(req_addr_o == exp_next, "R3 addr", int'(req_addr_o), int'(exp_next));
                check(int'(req_len_o) == min_len(exp_end - exp_next), "R3 len",
                      int'(req_len_o), min_len(exp_end - exp_next));
                check(req_tag_o == exp_tag, "R5 tag order", int'(req_tag_o), int'(exp_tag));
                check(!out_v[req_tag_o], "R5 tag reuse", 1, 0);
                out_v[req_tag_o] = 1;
                out_a[req_tag_o] = req_addr_o;
                exp_next = exp_next + ADDR_W'(req_len_o);
                exp_tag = (int'(exp_tag) == SLOTS - 1) ? '0 : exp_tag + 1'b1;
                issued_n++;
                issued_bytes += int'(req_len_o);
                last_req_cyc = cyc;
                if (ovf_chk)
                    check(issued_bytes - read_bytes <= DEPTH, "R4 space",
                          issued_bytes - read_bytes, DEPTH);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        start_i = 0; stop_i = 0; cpl_valid_i = 0; rd_en_i = 0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_start(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] n);
        start_i = 1; start_addr_i = a; start_len_i = n;
        exp_next = a; exp_end = a + n; rd_addr = a;
        issued_bytes = 0; read_bytes = 0;
        step();
    endtask

    // Drive one cycle with an optional completion and an optional read; checks read data.
    task automatic cycle_mix(input bit do_cpl, input int tag, input bit do_rd, input int cnt,
                             output bit ok);
        if (do_cpl) begin
            cpl_valid_i = 1; cpl_tag_i = TAG_W'(tag);
            for (int k = 0; k < MAX_REQ; k++)
                cpl_data_i[8*k +: 8] = byte_of(out_a[tag] + ADDR_W'(k));
            out_v[tag] = 0;
        end
        if (do_rd) begin rd_en_i = 1; rd_cnt_i = 3'(cnt); end
        @(negedge clk);
        ok = do_rd && rd_ok_o;
        if (ok) begin
            for (int j = 0; j < cnt; j++)
                check(rd_data_o[8*j +: 8] == byte_of(rd_addr + ADDR_W'(j)), "R6 data order",
                      int'(rd_data_o[8*j +: 8]), int'(byte_of(rd_addr + ADDR_W'(j))));
            rd_addr = rd_addr + ADDR_W'(cnt);
            read_bytes += cnt;
        end
        step();
    endtask

    function automatic int pick_out();
        int r;
        r = int'($urandom % SLOTS);
        for (int i = 0; i < SLOTS; i++)
            if (out_v[(r + i) % SLOTS]) return (r + i) % SLOTS;
        return -1;
    endfunction

    task automatic drain(input int len);
        bit ok;
        int t, guard;
        guard = 0;
        while (read_bytes < len && guard < 3000) begin
            t = pick_out();
            cycle_mix(t >= 0 && ($urandom % 3 != 0), t, $urandom % 2 == 1,
                      1 + int'($urandom % 4), ok);
            guard++;
        end
        check(read_bytes == len, "R6 bytes delivered", read_bytes, len);
    endtask

    initial begin
        bit ok;
        int n0, e0, i0, len;
        for (int i = 0; i < SLOTS; i++) out_v[i] = 0;
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1;
        // R1: quiet after reset, empty FIFO refuses a read
        rd_en_i = 1; rd_cnt_i = 3'd1;
        @(negedge clk);
        check(!req_valid_o && !eob_o && !idle_o, "R1 quiet", int'(req_valid_o), 0);
        check(!rd_ok_o, "R1 empty", int'(rd_ok_o), 0);
        step();

        // Slot limit, space limit, in-order commit, refused read, ignored start
        do_start(32'h100, 40);
        e0 = eob_n;
        wait_n(8);
        check(issued_n == 4, "R4 slot limit", issued_n, 4);
        for (int t = 3; t >= 0; t--) cycle_mix(1, t, 0, 0, ok);
        wait_n(8);
        check(issued_n == 6, "R4 space limit", issued_n, 6);
        start_i = 1; start_addr_i = 32'h9000; start_len_i = 8;   // R2: must be ignored
        step();
        wait_n(2);
        for (int r = 0; r < 4; r++) begin
            cycle_mix(0, 0, 1, 4, ok);
            check(ok, "R8 read granted", int'(ok), 1);
        end
        cycle_mix(0, 0, 1, 4, ok);
        check(!ok, "R8 read refused", int'(ok), 0);
        cycle_mix(1, 0, 0, 0, ok);
        cycle_mix(1, 1, 0, 0, ok);
        wait_n(4);
        cycle_mix(0, 0, 1, 4, ok);
        check(ok && read_bytes == 20, "R8 nothing removed", read_bytes, 20);
        drain(40);
        check(issued_bytes == 40, "R2 fill unchanged", issued_bytes, 40);
        check(eob_n == e0 + 1, "R9 eob once", eob_n - e0, 1);
        check(eob_cyc == last_req_cyc + 1, "R9 eob timing", eob_cyc, last_req_cyc + 1);
        wait_n(4);

        // Stop with requests in flight
        do_start(32'h2000, 64);
        wait_n(6);
        ovf_chk = 0;
        e0 = eob_n;
        stop_i = 1;
        step();
        n0 = issued_n;
        wait_n(4);
        check(issued_n == n0, "R7 no issue after stop", issued_n, n0);
        check(eob_n == e0 + 1, "R9 eob on stop", eob_n - e0, 1);
        i0 = idle_n;
        for (int t = 0; t < SLOTS; t++) if (out_v[t]) cycle_mix(1, t, 0, 0, ok);
        wait_n(6);
        check(idle_n == i0 + 1, "R10 idle once", idle_n - i0, 1);
        cycle_mix(0, 0, 1, 1, ok);
        check(!ok, "R7 canceled data dropped", int'(ok), 0);
        ovf_chk = 1;

        // Zero-length fill: nothing issued, no end-of-block event
        n0 = issued_n; e0 = eob_n;
        do_start(32'h50, 0);
        wait_n(4);
        check(issued_n == n0 && eob_n == e0, "R9 empty fill", issued_n - n0, 0);

        // Random fills
        for (int f = 0; f < 6; f++) begin
            len = 1 + int'($urandom % 60);
            e0 = eob_n;
            do_start($urandom, ADDR_W'(len));
            drain(len);
            check(issued_bytes == len, "R3 bytes issued", issued_bytes, len);
            check(eob_n == e0 + 1, "R9 eob per fill", eob_n - e0, 1);
            wait_n(3);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule